// File: doc/BRIEF.md
# Dual-Clock FIFO with Handshaked Pointer Exchange

This block moves data words from a write clock domain to an unrelated read clock domain through a small dual-port storage array. The write side pushes a word with `wr_en` while `wr_full` is low. The read side pops a word with `rd_en` while `rd_empty` is low. The popped word appears on `rd_data` one read-clock cycle later.

Each domain counts its own position with a binary pointer that is one bit wider than the storage address. It learns the other side's position through a four-phase request/acknowledge exchange. Both the request and the acknowledge pass through multi-stage synchronizers. Each side judges full or empty from its own live pointer and the last copy of the remote pointer it received.

The remote copy can only lag the real value. Because of that, full can appear too early on the write side and empty can linger too long on the read side, but neither flag can ever be late. When one exchange finishes, a new one starts with the pointer's current value, however far it has moved in the meantime. Each domain has its own reset input.

Top module: `xdom_fifo`

## Requirements
- R1: After reset, `rd_empty` is 1, `wr_full` is 0 and `rd_data` is 0.
- R2: Words leave in the order they were written. A read accepted at a read-clock rising edge (`rd_en`=1 and `rd_empty`=0) presents its word on `rd_data` right after that edge, and the word is held until the next accepted read.
- R3: After DEPTH accepted writes with no read in between, `wr_full` is 1. A write attempted while `wr_full` is 1 is dropped: it changes neither the stored words nor the write pointer.
- R4: A read attempted while `rd_empty` is 1 is dropped: `rd_data` keeps its value and the read pointer does not move, so the next word written is the next word read.
- R5: After a write, `rd_empty` stays 1 until the new write pointer has crossed through the handshake. It is still 1 at the first read-clock falling edge after the write edge. The read side never sees more words than were written.
- R6: After a read from a full FIFO, `wr_full` stays 1 until the new read pointer has crossed. It is still 1 at the first write-clock falling edge after the read. It then falls within a bounded number of cycles.
- R7: Pointers cross as plain binary values. A new exchange starts by capturing the pointer's current value, so a burst of writes made during one exchange becomes fully visible at the read side. A received pointer copy never moves backwards.
- R8: Write and read domains each have their own active-high reset, asserted asynchronously and released synchronously to their own clock. After both resets, even when they are released in different cycles, the FIFO is empty, not full, and works normally.
- R9: Pointers are ADDR_W+1 bits wide, so full and empty stay distinct after the pointers wrap many times.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| wr_clk | input | 1 | Write-domain clock |
| wr_rst | input | 1 | Write-domain reset, active high |
| wr_en | input | 1 | Write request |
| wr_data | input | DATA_W | Word to write |
| wr_full | output | 1 | No room (possibly early) |
| rd_clk | input | 1 | Read-domain clock |
| rd_rst | input | 1 | Read-domain reset, active high |
| rd_en | input | 1 | Read request |
| rd_data | output | DATA_W | Registered read word |
| rd_empty | output | 1 | Nothing to read (possibly early) |

## Verification
On every cycle, the checker confirms four things. Neither domain's view of occupancy ever goes beyond DEPTH. A write while full or a read while empty leaves its pointer untouched. `rd_data` changes only on an accepted read. Received pointer copies only move forward.

Only the bench scenarios can show the rest:
- the word order;
- the exact cycle the read word appears;
- that full and empty stay set for at least one cycle after the other side has moved;
- that the flags release after a burst;
- correct recovery from resets released in different cycles.

// File: rtl/xdf_pkg.sv
package xdf_pkg;
   // Sender side of the four-phase pointer exchange
   typedef enum logic [1:0] {
      HS_LOAD     = 2'd0,
      HS_WAIT_ACK = 2'd1,
      HS_WAIT_REL = 2'd2
   } hs_state_e;
endpackage

// File: rtl/xdf_sync.sv
module xdf_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst,
   input  logic d,
   output logic q
);
   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("xdf_sync: STAGES must be at least 2");
      end
   endgenerate

   logic [STAGES-1:0] chain_q;

   always_ff @(posedge clk or posedge rst) begin
      if (rst) chain_q <= '0;
      else     chain_q <= {chain_q[STAGES-2:0], d};
   end

   assign q = chain_q[STAGES-1];
endmodule

// File: rtl/xdf_ram.sv
module xdf_ram #(
   parameter int DATA_W = 8,
   parameter int ADDR_W = 3
) (
   input  logic              wr_clk,
   input  logic              we,
   input  logic [ADDR_W-1:0] waddr,
   input  logic [DATA_W-1:0] wdata,
   input  logic              rd_clk,
   input  logic              rd_rst,
   input  logic              re,
   input  logic [ADDR_W-1:0] raddr,
   output logic [DATA_W-1:0] rdata
);
   localparam int DEPTH = 1 << ADDR_W;

   logic [DATA_W-1:0] mem [DEPTH];

   always_ff @(posedge wr_clk) begin
      if (we) mem[waddr] <= wdata;
   end

   always_ff @(posedge rd_clk or posedge rd_rst) begin
      if (rd_rst)  rdata <= '0;
      else if (re) rdata <= mem[raddr];
   end
endmodule

// File: rtl/xdf_ptr_xfer.sv
module xdf_ptr_xfer
   import xdf_pkg::*;
#(
   parameter int PW     = 4,
   parameter int STAGES = 2
) (
   input  logic          src_clk,
   input  logic          src_rst,
   input  logic [PW-1:0] src_val,
   input  logic          dst_clk,
   input  logic          dst_rst,
   output logic [PW-1:0] dst_val
);
   hs_state_e     st_q;
   logic [PW-1:0] hold_q;
   logic          req_q, ack_q;
   logic          req_at_dst, ack_at_src;

   // Source side: capture, raise request, wait for ack, drop, wait release
   always_ff @(posedge src_clk or posedge src_rst) begin
      if (src_rst) begin
         st_q   <= HS_LOAD;
         hold_q <= '0;
         req_q  <= 1'b0;
      end else begin
         case (st_q)
            HS_LOAD: begin
               hold_q <= src_val;
               req_q  <= 1'b1;
               st_q   <= HS_WAIT_ACK;
            end
            HS_WAIT_ACK: begin
               if (ack_at_src) begin
                  req_q <= 1'b0;
                  st_q  <= HS_WAIT_REL;
               end
            end
            HS_WAIT_REL: begin
               if (!ack_at_src) st_q <= HS_LOAD;
            end
            default: st_q <= HS_LOAD;
         endcase
      end
   end

   xdf_sync #(.STAGES(STAGES)) u_req_sync (
      .clk(dst_clk), .rst(dst_rst), .d(req_q), .q(req_at_dst)
   );

   xdf_sync #(.STAGES(STAGES)) u_ack_sync (
      .clk(src_clk), .rst(src_rst), .d(ack_q), .q(ack_at_src)
   );

   // Destination side: hold_q is stable while the request is seen high
   always_ff @(posedge dst_clk or posedge dst_rst) begin
      if (dst_rst) begin
         ack_q   <= 1'b0;
         dst_val <= '0;
      end else if (req_at_dst && !ack_q) begin
         dst_val <= hold_q;
         ack_q   <= 1'b1;
      end else if (!req_at_dst && ack_q) begin
         ack_q   <= 1'b0;
      end
   end
endmodule

// File: rtl/xdom_fifo.sv
module xdom_fifo #(
   parameter int DATA_W      = 8,
   parameter int ADDR_W      = 3,
   parameter int SYNC_STAGES = 2
) (
   input  logic              wr_clk,
   input  logic              wr_rst,
   input  logic              wr_en,
   input  logic [DATA_W-1:0] wr_data,
   output logic              wr_full,
   input  logic              rd_clk,
   input  logic              rd_rst,
   input  logic              rd_en,
   output logic [DATA_W-1:0] rd_data,
   output logic              rd_empty
);
   localparam int PW = ADDR_W + 1;
   localparam logic [PW-1:0] WRAP_DIFF = {1'b1, {ADDR_W{1'b0}}};

   generate
      if (DATA_W < 1) begin : g_bad_width
         $error("xdom_fifo: DATA_W must be positive");
      end
      if (ADDR_W < 1 || ADDR_W > 12) begin : g_bad_depth
         $error("xdom_fifo: ADDR_W must be within 1..12");
      end
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("xdom_fifo: SYNC_STAGES must be at least 2");
      end
   endgenerate

   logic [PW-1:0] wr_ptr_q, rd_ptr_q;
   logic [PW-1:0] rptr_at_wr, wptr_at_rd;
   logic          wr_accept, rd_accept;

   // Write domain: local pointer against last received read pointer
   assign wr_full   = ((wr_ptr_q ^ rptr_at_wr) == WRAP_DIFF);
   assign wr_accept = wr_en && !wr_full;

   always_ff @(posedge wr_clk or posedge wr_rst) begin
      if (wr_rst)         wr_ptr_q <= '0;
      else if (wr_accept) wr_ptr_q <= wr_ptr_q + 1'b1;
   end

   // Read domain: local pointer against last received write pointer
   assign rd_empty  = (rd_ptr_q == wptr_at_rd);
   assign rd_accept = rd_en && !rd_empty;

   always_ff @(posedge rd_clk or posedge rd_rst) begin
      if (rd_rst)         rd_ptr_q <= '0;
      else if (rd_accept) rd_ptr_q <= rd_ptr_q + 1'b1;
   end

   xdf_ram #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_ram (
      .wr_clk (wr_clk),
      .we     (wr_accept),
      .waddr  (wr_ptr_q[ADDR_W-1:0]),
      .wdata  (wr_data),
      .rd_clk (rd_clk),
      .rd_rst (rd_rst),
      .re     (rd_accept),
      .raddr  (rd_ptr_q[ADDR_W-1:0]),
      .rdata  (rd_data)
   );

   xdf_ptr_xfer #(.PW(PW), .STAGES(SYNC_STAGES)) u_wptr_xfer (
      .src_clk (wr_clk),
      .src_rst (wr_rst),
      .src_val (wr_ptr_q),
      .dst_clk (rd_clk),
      .dst_rst (rd_rst),
      .dst_val (wptr_at_rd)
   );

   xdf_ptr_xfer #(.PW(PW), .STAGES(SYNC_STAGES)) u_rptr_xfer (
      .src_clk (rd_clk),
      .src_rst (rd_rst),
      .src_val (rd_ptr_q),
      .dst_clk (wr_clk),
      .dst_rst (wr_rst),
      .dst_val (rptr_at_wr)
   );
endmodule

// File: rtl/xdf_chk.sv
module xdf_chk #(
   parameter int DATA_W = 8,
   parameter int ADDR_W = 3
) (
   input logic              wr_clk,
   input logic              wr_rst,
   input logic              wr_en,
   input logic              wr_full,
   input logic [ADDR_W:0]   wr_ptr,
   input logic [ADDR_W:0]   rptr_w,
   input logic              rd_clk,
   input logic              rd_rst,
   input logic              rd_en,
   input logic              rd_empty,
   input logic [ADDR_W:0]   rd_ptr,
   input logic [ADDR_W:0]   wptr_r,
   input logic [DATA_W-1:0] rd_data
);
   localparam int PW = ADDR_W + 1;
   localparam logic [PW-1:0] DEPTH_P = PW'(1 << ADDR_W);

   AST_NO_OVERFLOW: assert property (@(posedge wr_clk) disable iff (wr_rst)
      PW'(wr_ptr - rptr_w) <= DEPTH_P); // R3

   AST_FULL_WRITE_DROPPED: assert property (@(posedge wr_clk) disable iff (wr_rst)
      (wr_en && wr_full) |=> (wr_ptr == $past(wr_ptr))); // R3

   AST_NO_UNDERFLOW: assert property (@(posedge rd_clk) disable iff (rd_rst)
      PW'(wptr_r - rd_ptr) <= DEPTH_P); // R5

   AST_EMPTY_READ_DROPPED: assert property (@(posedge rd_clk) disable iff (rd_rst)
      (rd_en && rd_empty) |=> $stable(rd_ptr)); // R4

   AST_RDATA_HELD: assert property (@(posedge rd_clk) disable iff (rd_rst)
      !(rd_en && !rd_empty) |=> $stable(rd_data)); // R2

   AST_WPTR_COPY_FORWARD: assert property (@(posedge rd_clk) disable iff (rd_rst)
      PW'(wptr_r - $past(wptr_r)) <= DEPTH_P); // R7

   AST_RPTR_COPY_FORWARD: assert property (@(posedge wr_clk) disable iff (wr_rst)
      PW'(rptr_w - $past(rptr_w)) <= DEPTH_P); // R7
endmodule

bind xdom_fifo xdf_chk #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_chk (
   .wr_clk   (wr_clk),
   .wr_rst   (wr_rst),
   .wr_en    (wr_en),
   .wr_full  (wr_full),
   .wr_ptr   (wr_ptr_q),
   .rptr_w   (rptr_at_wr),
   .rd_clk   (rd_clk),
   .rd_rst   (rd_rst),
   .rd_en    (rd_en),
   .rd_empty (rd_empty),
   .rd_ptr   (rd_ptr_q),
   .wptr_r   (wptr_at_rd),
   .rd_data  (rd_data)
);

// File: tb/sim_xdom_fifo.sv
module sim_xdom_fifo;
   localparam int CLK_PERIOD = 10;
   localparam int RD_PERIOD  = 14;
   localparam int DATA_W     = 8;
   localparam int ADDR_W     = 3;
   localparam int DEPTH      = 1 << ADDR_W;
   localparam int NPAT       = 12;
   localparam logic [DATA_W-1:0] PAT [NPAT] = '{
      8'h00, 8'hFF, 8'hA5, 8'h5A, 8'h01, 8'h80,
      8'h7E, 8'h81, 8'h33, 8'hCC, 8'h0F, 8'hF0 };

   logic wr_clk = 0, rd_clk = 0;
   logic wr_rst = 1, rd_rst = 1;
   logic wr_en = 0, rd_en = 0;
   logic [DATA_W-1:0] wr_data = '0;
   logic [DATA_W-1:0] rd_data;
   logic wr_full, rd_empty;

   int checks = 0;
   int fails  = 0;
   bit done   = 0;

   always #(CLK_PERIOD/2) wr_clk = ~wr_clk;
   always #(RD_PERIOD/2)  rd_clk = ~rd_clk;

   xdom_fifo #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .SYNC_STAGES(2)) u0 (
      .wr_clk(wr_clk), .wr_rst(wr_rst), .wr_en(wr_en), .wr_data(wr_data),
      .wr_full(wr_full), .rd_clk(rd_clk), .rd_rst(rd_rst), .rd_en(rd_en),
      .rd_data(rd_data), .rd_empty(rd_empty));

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic push(input logic [DATA_W-1:0] d);
      @(negedge wr_clk);
      wr_en = 1; wr_data = d;
      @(negedge wr_clk);
      wr_en = 0;
   endtask

   task automatic pop(input logic [DATA_W-1:0] exp, input string req);
      int n = 0;
      @(negedge rd_clk);
      while (rd_empty && n < 100) begin
         @(negedge rd_clk);
         n++;
      end
      if (rd_empty) begin
         chk(0, req, 1, 0);
      end else begin
         rd_en = 1;
         @(negedge rd_clk);
         rd_en = 0;
         chk(rd_data == exp, req, rd_data, exp);
      end
   endtask

   task automatic settle();
      repeat (40) @(negedge rd_clk);
   endtask

   initial begin
      repeat (150000) @(posedge wr_clk);
      if (!done) begin
         fails++;
         $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end

   initial begin
      repeat (4) @(negedge rd_clk);
      wr_rst = 0; rd_rst = 0;
      repeat (3) @(negedge rd_clk);
      // R1 reset state
      chk(rd_empty == 1, "R1 empty", rd_empty, 1);
      chk(wr_full == 0,  "R1 full",  wr_full, 0);
      chk(rd_data == 0,  "R1 data",  rd_data, 0);

      // R2 table walk: each word written then read back
      for (int i = 0; i < NPAT; i++) begin
         push(PAT[i]);
         pop(PAT[i], "R2 order");
      end

      // R3 fill to DEPTH, overflow attempt dropped
      settle();
      for (int i = 0; i < DEPTH; i++) begin
         @(negedge wr_clk);
         chk(wr_full == 0, "R3 not full yet", wr_full, 0);
         wr_en = 1; wr_data = 8'h40 + 8'(i);
         @(negedge wr_clk);
         wr_en = 0;
      end
      chk(wr_full == 1, "R3 full at DEPTH", wr_full, 1);
      @(negedge wr_clk); wr_en = 1; wr_data = 8'hEE;
      @(negedge wr_clk); wr_en = 0;
      chk(wr_full == 1, "R3 still full", wr_full, 1);

      // R6 full stays set until read pointer crosses, then releases
      pop(8'h40, "R3 first word");
      @(negedge wr_clk);
      chk(wr_full == 1, "R6 full early", wr_full, 1);
      begin
         int n = 0;
         while (wr_full && n < 60) begin
            @(negedge wr_clk);
            n++;
         end
         chk(wr_full == 0, "R6 full released", wr_full, 0);
      end
      for (int i = 1; i < DEPTH; i++) pop(8'h40 + 8'(i), "R3 no overwrite");

      // R4 read while empty is dropped
      settle();
      chk(rd_empty == 1, "R4 empty after drain", rd_empty, 1);
      @(negedge rd_clk); rd_en = 1;
      @(negedge rd_clk); rd_en = 0;
      chk(rd_data == 8'h47, "R4 data held", rd_data, 8'h47);
      push(8'h99);
      pop(8'h99, "R4 pointer unchanged");

      // R5 empty stays set until the write pointer crosses
      settle();
      push(8'h55);
      @(negedge rd_clk);
      chk(rd_empty == 1, "R5 empty early", rd_empty, 1);
      pop(8'h55, "R5 word arrives");

      // R7 burst during one exchange fully delivered
      settle();
      for (int i = 0; i < 5; i++) push(8'hB0 + 8'(i));
      for (int i = 0; i < 5; i++) pop(8'hB0 + 8'(i), "R7 burst");

      // R9 wrap-around rounds
      for (int r = 0; r < 3; r++) begin
         settle();
         for (int i = 0; i < DEPTH; i++) push(8'(r * 16 + i));
         chk(wr_full == 1, "R9 full after wrap", wr_full, 1);
         for (int i = 0; i < DEPTH; i++) pop(8'(r * 16 + i), "R9 data after wrap");
         settle();
         chk(rd_empty == 1, "R9 empty after wrap", rd_empty, 1);
         chk(wr_full == 0, "R9 not full after wrap", wr_full, 0);
      end

      // R8 separate resets released in different cycles
      push(8'h11); push(8'h22); push(8'h33);
      settle();
      @(negedge wr_clk);
      wr_rst = 1; rd_rst = 1;
      repeat (3) @(negedge wr_clk);
      wr_rst = 0;
      repeat (5) @(negedge rd_clk);
      rd_rst = 0;
      settle();
      chk(rd_empty == 1, "R8 empty after resets", rd_empty, 1);
      chk(wr_full == 0, "R8 not full after resets", wr_full, 0);
      push(8'h3C);
      pop(8'h3C, "R8 works after resets");

      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end
endmodule